// File: doc/BRIEF.md
# Twisted-Pair Collision Detector with Jabber Watchdog

This block watches a twisted-pair port for simultaneous transmit and receive activity and reports it as a collision. When the overlap ends, the collision report is stretched by a set number of bit times. The block also guards the line against a transmitter that will not let go. If transmit activity lasts longer than a configured limit, the block shuts the transmitter off through a gating output and forces the collision indication on. It also sets a status bit that stays set until it is cleared.

Recovery from that jabber condition needs a long, unbroken idle period on the transmit side. Any transmit activity during the recovery period starts the count again. While the link is in its failed state the collision indication stays low, whatever the other inputs do. Both time limits are counted in clock cycles, so the block can run at any clock rate and a bench can use short limits. The tail length is counted in bit-time ticks supplied from outside.

Top module: `coll_jab_guard`

## Requirements
- R1: While reset is held and just after it, collision is 0, txEnable is 1 and jabberFlag is 0.
- R2: When txActive, rxActive and linkPass are all 1 at a clock edge, collision is 1 after that edge.
- R3: Once the overlap is first seen absent at an edge, collision stays 1 until TAIL_BITS bitTick pulses have been sampled on later edges. It drops at the edge that samples the last of them. A tick sampled during the overlap, or on the edge where the overlap ends, is not counted.
- R4: An overlap that starts again during the tail keeps collision at 1, and the tail starts fresh when that new overlap ends.
- R5: When linkPass is 0 at an edge, collision is 0 after that edge and any pending tail is discarded. Restoring the link does not bring the tail back.
- R6: When txActive is 1 on JAB_LIMIT consecutive edges, txEnable goes to 0 after the last of them, and collision goes to 1 if linkPass is 1. A burst one edge shorter leaves txEnable at 1.
- R7: jabberFlag goes to 1 on the same edge at which txEnable goes to 0. It stays set for as long as it is not cleared, whatever the rest of the block is doing.
- R8: During jabber, after UNJAB_LIMIT consecutive edges with txActive at 0, txEnable returns to 1 and the forced collision is released at that edge.
- R9: A single edge with txActive at 1 during the recovery period restarts the idle count from zero.
- R10: A jabClear pulse clears jabberFlag at the next edge, even during jabber, without releasing the jabber state. Setting the flag takes priority over a clear on the same edge. The flag is never cleared by the end of recovery.
- R11: While jabber is active, a failed link still forces collision to 0 and leaves txEnable at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txActive | input | 1 | Transmit activity present on the pair |
| rxActive | input | 1 | Receive activity present on the pair |
| linkPass | input | 1 | 1 when the link is up, 0 in the failed state |
| bitTick | input | 1 | One-cycle pulse per bit time |
| jabClear | input | 1 | One-cycle strobe that clears jabberFlag |
| collision | output | 1 | Collision indication, including tail and jabber forcing |
| txEnable | output | 1 | Gate for the transmit driver, 0 while jabber is active |
| jabberFlag | output | 1 | Sticky jabber status |

## Verification
The assertions check the following on every cycle:
- A failed link masks collision.
- An overlap always yields collision on the next cycle.
- A closed transmit gate implies collision while the link is up.
- The flag is set whenever the gate closes.
- The flag falls only after a clear strobe.
- The gate reopens only after an idle transmit sample.

Only the bench scenarios can show the exact cycle counts: the tail length in ticks, the edge at which jabber is entered, the restart of the recovery count, and the exact recovery edge. The same applies to set-over-clear priority and to tail loss across a link drop.

// File: rtl/coll_jab_pkg.sv
package coll_jab_pkg;

  typedef enum logic {
    GUARD_ARMED  = 1'b0,
    GUARD_JABBED = 1'b1
  } guardState_t;

  // Strobes issued by the control to the counter datapath.
  typedef struct packed {
    logic runInc;    // count one more edge of transmit activity
    logic runClr;    // restart the transmit run length
    logic idleInc;   // count one more idle edge while jabbed
    logic idleClr;   // restart the idle run length
    logic tailLoad;  // overlap just ended: load the tail length
    logic tailStep;  // a bit time passed
    logic tailClr;   // drop any pending tail
  } ctlStrobes_t;

endpackage

// File: rtl/coll_jab_dp.sv
module coll_jab_dp
  import coll_jab_pkg::*;
#(
  parameter int JAB_LIMIT   = 1_500_000,
  parameter int UNJAB_LIMIT = 25_000_000,
  parameter int TAIL_BITS   = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t strb,
  output logic        runAtLimit,
  output logic        idleAtLimit,
  output logic        tailBusy
);

  localparam int RUN_W  = (JAB_LIMIT   > 2) ? $clog2(JAB_LIMIT)   : 1;
  localparam int IDLE_W = (UNJAB_LIMIT > 2) ? $clog2(UNJAB_LIMIT) : 1;
  localparam logic [RUN_W-1:0]  RUN_LAST  = RUN_W'(JAB_LIMIT - 1);
  localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(UNJAB_LIMIT - 1);

  logic [RUN_W-1:0]  runCnt;
  logic [IDLE_W-1:0] idleCnt;

  // Length of the current unbroken transmit burst, in clock edges.
  always_ff @(posedge clk) begin
    if (!rstN || strb.runClr) runCnt <= '0;
    else if (strb.runInc && runCnt != RUN_LAST) runCnt <= runCnt + 1'b1;
  end

  // Length of the current unbroken idle period while jabbed.
  always_ff @(posedge clk) begin
    if (!rstN || strb.idleClr) idleCnt <= '0;
    else if (strb.idleInc && idleCnt != IDLE_LAST) idleCnt <= idleCnt + 1'b1;
  end

  assign runAtLimit  = (runCnt == RUN_LAST);
  assign idleAtLimit = (idleCnt == IDLE_LAST);

  generate
    if (TAIL_BITS > 0) begin : gTail
      localparam int TAIL_W = $clog2(TAIL_BITS + 1);
      logic [TAIL_W-1:0] tailCnt;
      always_ff @(posedge clk) begin
        if (!rstN || strb.tailClr) tailCnt <= '0;
        else if (strb.tailLoad) tailCnt <= TAIL_W'(TAIL_BITS);
        else if (strb.tailStep && tailCnt != '0) tailCnt <= tailCnt - 1'b1;
      end
      assign tailBusy = (tailCnt != '0);
    end else begin : gNoTail
      assign tailBusy = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/coll_jab_ctrl.sv
module coll_jab_ctrl
  import coll_jab_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        txActive,
  input  logic        rxActive,
  input  logic        linkPass,
  input  logic        bitTick,
  input  logic        jabClear,
  input  logic        runAtLimit,
  input  logic        idleAtLimit,
  input  logic        tailBusy,
  output ctlStrobes_t strb,
  output logic        collision,
  output logic        txEnable,
  output logic        jabberFlag
);

  guardState_t state, stateNext;
  logic overlapQ, linkQ, flagQ;
  logic overlapNow, jabEnter, jabExit;

  assign overlapNow = linkPass && txActive && rxActive;
  assign jabEnter   = (state == GUARD_ARMED)  && txActive  && runAtLimit;
  assign jabExit    = (state == GUARD_JABBED) && !txActive && idleAtLimit;

  always_comb begin
    strb          = '0;
    stateNext     = state;
    strb.tailLoad = overlapQ && !overlapNow && linkPass;
    strb.tailClr  = !linkPass || overlapNow;
    strb.tailStep = bitTick;
    case (state)
      GUARD_ARMED: begin
        strb.runInc  = txActive;
        strb.runClr  = !txActive;
        strb.idleClr = 1'b1;
        if (jabEnter) stateNext = GUARD_JABBED;
      end
      GUARD_JABBED: begin
        strb.runClr  = 1'b1;
        strb.idleInc = !txActive;
        strb.idleClr = txActive;
        if (jabExit) stateNext = GUARD_ARMED;
      end
      default: stateNext = GUARD_ARMED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= GUARD_ARMED;
      overlapQ <= 1'b0;
      linkQ    <= 1'b0;
      flagQ    <= 1'b0;
    end else begin
      state    <= stateNext;
      overlapQ <= overlapNow;
      linkQ    <= linkPass;
      if (jabEnter)      flagQ <= 1'b1;
      else if (jabClear) flagQ <= 1'b0;
    end
  end

  assign collision  = linkQ && (overlapQ || tailBusy || (state == GUARD_JABBED));
  assign txEnable   = (state == GUARD_ARMED);
  assign jabberFlag = flagQ;

endmodule

// File: rtl/coll_jab_guard.sv
module coll_jab_guard
  import coll_jab_pkg::*;
#(
  parameter int JAB_LIMIT   = 1_500_000,
  parameter int UNJAB_LIMIT = 25_000_000,
  parameter int TAIL_BITS   = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic txActive,
  input  logic rxActive,
  input  logic linkPass,
  input  logic bitTick,
  input  logic jabClear,
  output logic collision,
  output logic txEnable,
  output logic jabberFlag
);

  ctlStrobes_t strb;
  logic runAtLimit, idleAtLimit, tailBusy;

  coll_jab_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .txActive(txActive), .rxActive(rxActive), .linkPass(linkPass),
    .bitTick(bitTick), .jabClear(jabClear),
    .runAtLimit(runAtLimit), .idleAtLimit(idleAtLimit), .tailBusy(tailBusy),
    .strb(strb),
    .collision(collision), .txEnable(txEnable), .jabberFlag(jabberFlag)
  );

  coll_jab_dp #(
    .JAB_LIMIT(JAB_LIMIT), .UNJAB_LIMIT(UNJAB_LIMIT), .TAIL_BITS(TAIL_BITS)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .runAtLimit(runAtLimit), .idleAtLimit(idleAtLimit), .tailBusy(tailBusy)
  );

endmodule

// File: rtl/coll_jab_guard_chk.sv
module coll_jab_guard_chk (
  input logic clk,
  input logic rstN,
  input logic txActive,
  input logic rxActive,
  input logic linkPass,
  input logic jabClear,
  input logic collision,
  input logic txEnable,
  input logic jabberFlag
);

  // R2
  overlap_coll_chk: assert property (@(posedge clk) disable iff (!rstN)
    (linkPass && txActive && rxActive) |=> collision);

  // R5
  link_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    !linkPass |=> !collision);

  // R6
  jab_forces_coll_chk: assert property (@(posedge clk) disable iff (!rstN)
    linkPass |=> (txEnable || collision));

  // R7
  flag_on_gate_close_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txEnable) |-> jabberFlag);

  // R8
  reopen_after_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txEnable) |-> $past(!txActive));

  // R10
  flag_clear_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(jabberFlag) |-> $past(jabClear));

endmodule

bind coll_jab_guard coll_jab_guard_chk chk_i (
  .clk(clk), .rstN(rstN), .txActive(txActive), .rxActive(rxActive),
  .linkPass(linkPass), .jabClear(jabClear), .collision(collision),
  .txEnable(txEnable), .jabberFlag(jabberFlag)
);

// File: tb/coll_jab_guard_tb_top.sv
module coll_jab_guard_tb_top;

  localparam int JAB   = 40;
  localparam int UNJAB = 60;
  localparam int NVEC  = 21;

  logic clk = 1'b0;
  logic rstN, txActive, rxActive, linkPass, bitTick, jabClear;
  logic collision, txEnable, jabberFlag;
  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  coll_jab_guard #(.JAB_LIMIT(JAB), .UNJAB_LIMIT(UNJAB), .TAIL_BITS(2)) dut_i (
    .clk(clk), .rstN(rstN), .txActive(txActive), .rxActive(rxActive),
    .linkPass(linkPass), .bitTick(bitTick), .jabClear(jabClear),
    .collision(collision), .txEnable(txEnable), .jabberFlag(jabberFlag)
  );

  // {tx, rx, link, tick, expected collision, requirement number}
  localparam logic [8:0] VECS [NVEC] = '{
    9'b0010_0_0010,  // idle                      R2
    9'b1010_0_0010,  // tx alone                  R2
    9'b1110_1_0010,  // overlap                   R2
    9'b1111_1_0011,  // tick during overlap       R3
    9'b1011_1_0011,  // overlap ends, tail = 2    R3
    9'b1010_1_0011,
    9'b1011_1_0011,  // tail = 1
    9'b0010_1_0011,
    9'b0011_0_0011,  // tail done                 R3
    9'b0110_0_0010,  // rx alone
    9'b1110_1_0010,
    9'b0111_1_0100,  // tail = 2                  R4
    9'b0111_1_0100,  // tail = 1
    9'b1110_1_0100,  // overlap again             R4
    9'b1011_1_0100,  // fresh tail = 2
    9'b1011_1_0100,  // tail = 1
    9'b1100_0_0101,  // link fails                R5
    9'b1010_0_0101,  // link back, no tail        R5
    9'b1110_1_0010,
    9'b1100_0_0101,
    9'b0011_0_0101
  };

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic tickEdge();
    @(posedge clk);
    #2;
  endtask

  initial begin
    #(20 * 20000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; txActive = 1'b0; rxActive = 1'b0; linkPass = 1'b1;
    bitTick = 1'b0; jabClear = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    chk("R1", "collision", collision, 1'b0);
    chk("R1", "txEnable", txEnable, 1'b1);
    chk("R1", "jabberFlag", jabberFlag, 1'b0);
    @(negedge clk) rstN = 1'b1;
    tickEdge();
    chk("R1", "collision after release", collision, 1'b0);

    // Table walk: collision, tail and link masking.
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      {txActive, rxActive, linkPass, bitTick} = VECS[i][8:5];
      tickEdge();
      chk($sformatf("R%0d row %0d", VECS[i][3:0], i), "collision", collision, VECS[i][4]);
      chk($sformatf("R6 row %0d", i), "txEnable", txEnable, 1'b1);
    end
    @(negedge clk) {txActive, rxActive, linkPass, bitTick} = 4'b0010;
    repeat (3) @(posedge clk);

    // R6: a burst one edge short of the limit
    @(negedge clk) txActive = 1'b1;
    repeat (JAB - 1) @(posedge clk);
    #2;
    chk("R6", "txEnable short burst", txEnable, 1'b1);
    @(negedge clk) txActive = 1'b0;
    tickEdge();
    chk("R7", "jabberFlag short burst", jabberFlag, 1'b0);

    // R6/R7: full-length burst
    @(negedge clk) txActive = 1'b1;
    repeat (JAB - 1) @(posedge clk);
    #2;
    chk("R6", "txEnable at limit-1", txEnable, 1'b1);
    tickEdge();
    chk("R6", "txEnable jabbed", txEnable, 1'b0);
    chk("R6", "collision jabbed", collision, 1'b1);
    chk("R7", "jabberFlag set", jabberFlag, 1'b1);
    repeat (10) @(posedge clk);
    #2;
    chk("R7", "txEnable stays off", txEnable, 1'b0);

    // R11: failed link during jabber
    @(negedge clk) linkPass = 1'b0;
    tickEdge();
    chk("R11", "collision link fail", collision, 1'b0);
    chk("R11", "txEnable link fail", txEnable, 1'b0);
    @(negedge clk) linkPass = 1'b1;
    tickEdge();
    chk("R11", "collision link back", collision, 1'b1);

    // R9: recovery restart
    @(negedge clk) txActive = 1'b0;
    repeat (30) @(posedge clk);
    @(negedge clk) txActive = 1'b1;
    tickEdge();
    chk("R9", "txEnable after blip", txEnable, 1'b0);
    @(negedge clk) txActive = 1'b0;
    repeat (UNJAB - 1) @(posedge clk);
    #2;
    chk("R9", "txEnable before limit", txEnable, 1'b0);
    chk("R8", "collision before release", collision, 1'b1);
    tickEdge();
    chk("R8", "txEnable released", txEnable, 1'b1);
    chk("R8", "collision released", collision, 1'b0);
    chk("R10", "flag kept after recovery", jabberFlag, 1'b1);

    // R10: explicit clear
    @(negedge clk) jabClear = 1'b1;
    tickEdge();
    chk("R10", "flag cleared", jabberFlag, 1'b0);
    @(negedge clk) jabClear = 1'b0;

    // R10: set wins over clear on the entry edge
    @(negedge clk) txActive = 1'b1;
    repeat (JAB - 1) @(posedge clk);
    @(negedge clk) jabClear = 1'b1;
    tickEdge();
    chk("R10", "set beats clear", jabberFlag, 1'b1);
    chk("R6", "txEnable second jab", txEnable, 1'b0);
    tickEdge();
    chk("R10", "clear during jabber", jabberFlag, 1'b0);
    chk("R10", "txEnable kept off by clear", txEnable, 1'b0);
    @(negedge clk) begin jabClear = 1'b0; txActive = 1'b0; end
    repeat (UNJAB) @(posedge clk);
    #2;
    chk("R8", "txEnable second release", txEnable, 1'b1);
    chk("R10", "flag stays clear", jabberFlag, 1'b0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule